// File: doc/BRIEF.md
# Buck Converter Start-Up and Shutdown Sequencer

This block is the digital sequencer for a synchronous step-down controller. Before switching is allowed, it runs a fixed calibration window. Switching stays inhibited for the whole window. On the last cycle of the window, the block latches a 3-bit switching-frequency code, a 2-bit soft-start code and a mode bit that selects skip or continuous operation. It then drives a 10-bit reference DAC code from zero to full scale, which represents 0.6 V. The ramp takes 0.7, 1.4, 2.8 or 5.6 ms, as chosen by the latched soft-start code. When the code reaches full scale, the block reports that soft-start is done.

Forced continuous conduction is applied only once soft-start is done and the power-good flag is high. Dropping the enable in any active phase has three effects:

- Both gate drives are turned off.
- The reference and the done flag are cleared.
- An output-discharge switch is turned on.

The switch stays on until the regulator-supply-good flag falls or the enable comes back. A new enable always restarts the calibration window. Timing constants are derived from the clock-rate parameter. The default is a 4 MHz clock, so the calibration window is 1000 cycles and the 0.7 ms ramp base is 2800 cycles.

Top module: `buck_start_seq`

## Requirements
- R1: After reset, the block is idle and its outputs are as follows. `sw_en_o`, `ss_done_o`, `ccm_o` and `disch_o` are 0. `dac_o` is 0. `ss_code_o` and `fccm_code_o` are 0. `freq_code_o` is 3, the 500 kHz default.
- R2: The clock edge that first samples `en_i` high in idle or discharge starts calibration. `sw_en_o` stays low for the next 1000 edges (250 us at 4 MHz) and is high after the edge that follows them.
- R3: The three selection inputs are captured on the last calibration edge. Frequency codes 0 to 7 mean 250, 300, 400, 500, 650, 750, 850 and 970 kHz. `fccm_code_o` 1 means forced continuous and 0 means auto-skip. Later changes on the selection inputs do not alter the latched codes until the next calibration.
- R4: The DAC code starts at 0 when the ramp begins. It rises by at most one LSB per clock and never decreases while switching is allowed.
- R5: Let D = 2800·2^ss_code cycles, which gives 0.7, 1.4, 2.8 or 5.6 ms for ss_code 0 to 3. The DAC code reaches 1023 after exactly ceil(1023·D/1024) ramp cycles.
- R6: `ss_done_o` rises one clock after `dac_o` reaches 1023. It stays high with `dac_o` at 1023 while `en_i` stays high.
- R7: `ccm_o` is high only when all of the following hold: soft-start is done, the latched mode is forced continuous, and `pgood_i` was high at the previous edge. In auto-skip mode it stays low even with power-good high.
- R8: An edge that samples `en_i` low during calibration, ramp or run has the following effect on the next sample: `sw_en_o`, `ss_done_o` and `ccm_o` are low, `dac_o` is 0 and `disch_o` is high.
- R9: The discharge switch turns off on the edge that samples `vreg_ok_i` low during discharge, and the block then returns to idle. A drop of `vreg_ok_i` while enabled, or `en_i` low while idle, never turns the discharge switch on.
- R10: Re-asserting `en_i` during discharge turns the switch off and restarts the full calibration window before switching is allowed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous converter enable |
| freq_sel_i | input | 3 | Decoded switching-frequency selection |
| ss_sel_i | input | 2 | Decoded soft-start duration selection |
| fccm_sel_i | input | 1 | 1 = forced continuous, 0 = auto-skip |
| vreg_ok_i | input | 1 | Regulator supply above its lockout level |
| pgood_i | input | 1 | Output within power-good window |
| freq_code_o | output | 3 | Latched frequency code |
| ss_code_o | output | 2 | Latched soft-start code |
| fccm_code_o | output | 1 | Latched mode bit |
| sw_en_o | output | 1 | Switching allowed |
| dac_o | output | 10 | Reference DAC code, 1023 = 0.6 V |
| ss_done_o | output | 1 | Soft-start complete |
| ccm_o | output | 1 | Continuous conduction active |
| disch_o | output | 1 | Output-discharge switch on |

## Verification
The ramp is run with all four soft-start codes, each paired with a different frequency code and mode bit. The exact cycle of the done edge tells the four durations apart and exposes any off-by-one in the calibration count or the step accumulator. The selection inputs are flipped in the middle of each ramp, which separates capture at the end of the window from a plain pass-through. Shutdown is tried during calibration, mid-ramp and in steady run. A supply drop is tried both while enabled and during discharge, and re-enable is tried during discharge. Together these separate the exit paths of the sequencer.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_RAMP,
    ST_RUN,
    ST_DISCH
  } seq_state_e;

  localparam logic [2:0] FREQ_CODE_DEFAULT = 3'd3;  // 500 kHz
endpackage

// File: rtl/bss_cfg_hold.sv
`timescale 1ns/1ps
module bss_cfg_hold #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bss_ramp.sv
`timescale 1ns/1ps
module bss_ramp #(
  parameter int CLK_KHZ    = 4000,
  parameter int SS_BASE_US = 700,
  parameter int DAC_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [1:0]       ss_code_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             full_o
);
  localparam int BASE_CYC = SS_BASE_US * CLK_KHZ / 1000;
  localparam int STEP     = 1 << DAC_W;
  localparam int ACC_W    = $clog2(BASE_CYC * 8 + STEP) + 1;
  localparam logic [DAC_W-1:0] FULL = {DAC_W{1'b1}};

  logic [ACC_W-1:0] acc_q, sum, dur;

  assign dur    = ACC_W'(BASE_CYC) << ss_code_i;
  assign sum    = acc_q + ACC_W'(STEP);
  assign full_o = (dac_o == FULL);

  // error accumulator spreads STEP-1 increments evenly over dur cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dac_o <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      dac_o <= '0;
    end else if (run_i && !full_o) begin
      if (sum >= dur) begin
        acc_q <= sum - dur;
        dac_o <= dac_o + 1'b1;
      end else begin
        acc_q <= sum;
      end
    end
  end
endmodule

// File: rtl/bss_ctrl.sv
`timescale 1ns/1ps
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int CLK_KHZ = 4000,
  parameter int CAL_US  = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vreg_ok_i,
  input  logic pgood_i,
  input  logic fccm_q_i,
  input  logic ramp_full_i,
  output logic cal_end_o,
  output logic ramp_clr_o,
  output logic ramp_run_o,
  output logic sw_en_o,
  output logic ss_done_o,
  output logic ccm_o,
  output logic disch_o
);
  localparam int CAL_CYC = CAL_US * CLK_KHZ / 1000;
  localparam int TMR_W   = $clog2(CAL_CYC);

  seq_state_e       state_q, state_n;
  logic [TMR_W-1:0] tmr_q;
  logic             active;

  assign active    = (state_q == ST_RAMP) || (state_q == ST_RUN);
  assign cal_end_o = (state_q == ST_CAL) && en_i && (tmr_q == TMR_W'(CAL_CYC - 1));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (en_i) state_n = ST_CAL;
      ST_CAL:   if (!en_i) state_n = ST_DISCH;
                else if (cal_end_o) state_n = ST_RAMP;
      ST_RAMP:  if (!en_i) state_n = ST_DISCH;
                else if (ramp_full_i) state_n = ST_RUN;
      ST_RUN:   if (!en_i) state_n = ST_DISCH;
      ST_DISCH: if (en_i) state_n = ST_CAL;
                else if (!vreg_ok_i) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      ccm_o   <= 1'b0;
    end else begin
      state_q <= state_n;
      tmr_q   <= (state_q == ST_CAL) ? tmr_q + 1'b1 : '0;
      ccm_o   <= (state_q == ST_RUN) && en_i && fccm_q_i && pgood_i;
    end
  end

  assign ramp_clr_o = !active || !en_i;
  assign ramp_run_o = (state_q == ST_RAMP) && en_i;
  assign sw_en_o    = active;
  assign ss_done_o  = (state_q == ST_RUN);
  assign disch_o    = (state_q == ST_DISCH);
endmodule

// File: rtl/buck_start_seq.sv
`timescale 1ns/1ps
module buck_start_seq
  import bss_pkg::*;
#(
  parameter int CLK_KHZ    = 4000,
  parameter int CAL_US     = 250,
  parameter int SS_BASE_US = 700,
  parameter int DAC_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       freq_sel_i,
  input  logic [1:0]       ss_sel_i,
  input  logic             fccm_sel_i,
  input  logic             vreg_ok_i,
  input  logic             pgood_i,
  output logic [2:0]       freq_code_o,
  output logic [1:0]       ss_code_o,
  output logic             fccm_code_o,
  output logic             sw_en_o,
  output logic [DAC_W-1:0] dac_o,
  output logic             ss_done_o,
  output logic             ccm_o,
  output logic             disch_o
);
  localparam int CFG_W = 6;
  localparam logic [CFG_W-1:0] CFG_RST = {FREQ_CODE_DEFAULT, 2'd0, 1'b0};

  logic cal_end, ramp_clr, ramp_run, ramp_full;

  bss_cfg_hold #(.W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cal_end),
    .d_i    ({freq_sel_i, ss_sel_i, fccm_sel_i}),
    .q_o    ({freq_code_o, ss_code_o, fccm_code_o})
  );

  bss_ctrl #(.CLK_KHZ(CLK_KHZ), .CAL_US(CAL_US)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .vreg_ok_i   (vreg_ok_i),
    .pgood_i     (pgood_i),
    .fccm_q_i    (fccm_code_o),
    .ramp_full_i (ramp_full),
    .cal_end_o   (cal_end),
    .ramp_clr_o  (ramp_clr),
    .ramp_run_o  (ramp_run),
    .sw_en_o     (sw_en_o),
    .ss_done_o   (ss_done_o),
    .ccm_o       (ccm_o),
    .disch_o     (disch_o)
  );

  bss_ramp #(.CLK_KHZ(CLK_KHZ), .SS_BASE_US(SS_BASE_US), .DAC_W(DAC_W)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ramp_clr),
    .run_i     (ramp_run),
    .ss_code_i (ss_code_o),
    .dac_o     (dac_o),
    .full_o    (ramp_full)
  );
endmodule

// File: rtl/bss_chk.sv
`timescale 1ns/1ps
module bss_chk #(
  parameter int DAC_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [2:0]       freq_code_o,
  input logic [1:0]       ss_code_o,
  input logic             fccm_code_o,
  input logic             sw_en_o,
  input logic [DAC_W-1:0] dac_o,
  input logic             ss_done_o,
  input logic             ccm_o,
  input logic             disch_o
);
  localparam logic [DAC_W-1:0] FULL = {DAC_W{1'b1}};
  localparam logic [DAC_W-1:0] ONE  = {{(DAC_W-1){1'b0}}, 1'b1};

  // R3
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o && $past(sw_en_o) |-> $stable({freq_code_o, ss_code_o, fccm_code_o}));

  // R4
  dac_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o && $past(sw_en_o) |-> (dac_o == $past(dac_o)) || (dac_o == $past(dac_o) + ONE));

  // R6
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_done_o |-> dac_o == FULL);

  // R7
  ccm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccm_o |-> ss_done_o && fccm_code_o);

  // R8
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sw_en_o && !ss_done_o && !ccm_o);

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_en_o && disch_o));

  // R9
  disch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disch_o) |-> !$past(en_i));
endmodule

bind buck_start_seq bss_chk #(.DAC_W(DAC_W)) u_bss_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .freq_code_o (freq_code_o),
  .ss_code_o   (ss_code_o),
  .fccm_code_o (fccm_code_o),
  .sw_en_o     (sw_en_o),
  .dac_o       (dac_o),
  .ss_done_o   (ss_done_o),
  .ccm_o       (ccm_o),
  .disch_o     (disch_o)
);

// File: tb/buck_start_seq_bench.sv
`timescale 1ns/1ps
module buck_start_seq_bench;
  localparam int CAL  = 1000;
  localparam int BASE = 2800;
  localparam int FULL = 1023;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0] fsel = 3'd3;
  logic [1:0] ssel = 2'd0;
  logic msel = 1'b0, vreg = 1'b1, pg = 1'b0;
  logic [2:0] fcode;
  logic [1:0] scode;
  logic mcode, sw_en, ss_done, ccm, disch;
  logic [9:0] dac;

  buck_start_seq u_buck_start_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .freq_sel_i(fsel), .ss_sel_i(ssel),
    .fccm_sel_i(msel), .vreg_ok_i(vreg), .pgood_i(pg), .freq_code_o(fcode),
    .ss_code_o(scode), .fccm_code_o(mcode), .sw_en_o(sw_en), .dac_o(dac),
    .ss_done_o(ss_done), .ccm_o(ccm), .disch_o(disch)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int cyc; logic [2:0] f; logic [1:0] s; logic m;} exp_t;
  exp_t sb[$];

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: pushes the expected done edge and codes, then runs the start
  task automatic start(string tag, logic [2:0] f, logic [1:0] s, logic m);
    int dur, k, n;
    fsel = f; ssel = s; msel = m; en = 1'b1;
    dur = BASE << s;
    k = (FULL * dur + 1023) / 1024;
    sb.push_back('{cyc + CAL + k + 2, f, s, m});
    n = 0;
    while (!ss_done && n < 30000) begin
      step();
      n++;
      if (n == CAL)      chk({tag, " switching held off in calibration"}, sw_en, 0);
      if (n == CAL + 1)  chk({tag, " switching allowed after calibration"}, sw_en, 1);
      if (n == CAL + 10) begin fsel = ~f; ssel = ~s; msel = ~m; end
    end
    step();
    chk("R3 freq code kept after input change", fcode, f);
    chk("R3 ss code kept after input change", scode, s);
    chk("R3 mode kept after input change", mcode, m);
    chk("R6 done held", ss_done, 1);
  endtask

  task automatic stop_and_drain();
    en = 1'b0;
    step();
    chk("R8 discharge on", disch, 1);
    chk("R8 switching off", sw_en, 0);
    chk("R8 done cleared", ss_done, 0);
    chk("R8 dac cleared", dac, 0);
    chk("R8 ccm cleared", ccm, 0);
    step();
    chk("R9 discharge held while supply ok", disch, 1);
    vreg = 1'b0;
    step();
    chk("R9 discharge off on supply drop", disch, 0);
    vreg = 1'b1;
    step();
  endtask

  // monitor: pops expectations at each done edge
  initial begin
    logic pd, psw;
    logic [9:0] pdac;
    bit bad;
    exp_t e;
    pd = 1'b0; psw = 1'b0; pdac = '0; bad = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (sw_en && psw && dac != pdac && dac != pdac + 10'd1) bad = 1'b1;
      if (ss_done && !pd) begin
        if (sb.size() == 0) chk("R6 unexpected done", 1, 0);
        else begin
          e = sb.pop_front();
          chk("R5 done cycle", cyc, e.cyc);
          chk("R6 dac full one cycle before done", pdac, FULL);
          chk("R4 dac steps monotonic by one", bad, 0);
          chk("R3 latched freq", fcode, e.f);
          chk("R3 latched ss", scode, e.s);
          chk("R3 latched mode", mcode, e.m);
        end
      end
      if (!sw_en) bad = 1'b0;
      pd = ss_done; pdac = dac; psw = sw_en;
    end
  end

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1 sw_en reset", sw_en, 0);
    chk("R1 dac reset", dac, 0);
    chk("R1 done reset", ss_done, 0);
    chk("R1 ccm reset", ccm, 0);
    chk("R1 disch reset", disch, 0);
    chk("R1 freq default 500k", fcode, 3);
    chk("R1 ss code reset", scode, 0);
    chk("R1 mode reset", mcode, 0);
    repeat (3) step();
    chk("R9 no discharge from idle", disch, 0);

    start("R2", 3'd5, 2'd0, 1'b0);
    pg = 1'b1;
    repeat (2) step();
    chk("R7 auto-skip keeps ccm low", ccm, 0);
    vreg = 1'b0;
    repeat (2) step();
    chk("R9 supply drop while enabled no discharge", disch, 0);
    chk("R9 supply drop while enabled switching kept", sw_en, 1);
    vreg = 1'b1;
    stop_and_drain();

    pg = 1'b0;
    start("R2", 3'd0, 2'd1, 1'b1);
    step();
    chk("R7 ccm low without power good", ccm, 0);
    pg = 1'b1;
    step();
    chk("R7 ccm after power good", ccm, 1);
    pg = 1'b0;
    step();
    chk("R7 ccm drops with power good", ccm, 0);
    stop_and_drain();

    start("R2", 3'd7, 2'd2, 1'b0);
    stop_and_drain();
    start("R2", 3'd3, 2'd3, 1'b1);
    stop_and_drain();

    // abort inside calibration, then re-enable from discharge
    en = 1'b1;
    repeat (100) step();
    en = 1'b0;
    step();
    chk("R8 discharge after abort in calibration", disch, 1);
    chk("R8 switching off after abort in calibration", sw_en, 0);
    start("R10", 3'd2, 2'd0, 1'b0);
    chk("R10 discharge off after re-enable", disch, 0);

    // abort mid-ramp
    en = 1'b0;
    step();
    vreg = 1'b0; step(); vreg = 1'b1; step();
    en = 1'b1; fsel = 3'd1; ssel = 2'd1;
    repeat (CAL + 500) step();
    chk("R4 ramp in progress", (dac != 0 && dac != FULL), 1);
    en = 1'b0;
    step();
    chk("R8 dac zero after mid-ramp abort", dac, 0);
    chk("R8 discharge after mid-ramp abort", disch, 1);
    chk("R8 done low after mid-ramp abort", ss_done, 0);
    repeat (3) step();
    chk("R6 no pending done", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule